// File: doc/BRIEF.md
# Double-Buffered SPI Master

This block is a master-side serial peripheral interface engine. It owns the serial clock, the outgoing data line and a set of active-low slave selects, and it samples the incoming data line. A clock divider sets the serial clock. Each half period of the serial clock lasts `cfg_div` system clock cycles. Each character is 8 bits, sent most significant bit first. A bit is received in step with every bit that is sent, so every transfer also reads a full word from the slave.

The host side has one transmit holding register, one receive holding register and three flags. Writing a word while the shifter is idle starts a transfer on the next cycle. A word written while a transfer is running waits in the holding register. It is loaded at the character boundary, so the next character follows with no idle time and the slave select stays low. At every character boundary the received word is copied into the receive holding register.

The controller is a three-state machine:
- `S_IDLE`: selects released, clock at its idle level.
- `S_SHIFT`: 16 clock half periods per character.
- `S_TAIL`: one extra half period with the select still held.

The named transitions are:
- *launch* (`S_IDLE`→`S_SHIFT`): a pending word while enabled.
- *chain* (`S_SHIFT`→`S_SHIFT`): the character ends with a word pending.
- *drain* (`S_SHIFT`→`S_TAIL`): the character ends with nothing pending.
- *release* (`S_TAIL`→`S_IDLE`): the tail half period is over.

Top module: `spim_master`

## Requirements
- R1: After reset:
  - `cs_n` is all ones and `busy` is 0.
  - `tx_empty` is 1, `rx_full` is 0 and `overrun` is 0.
  - While idle, `sck` equals `cfg_cpol`.
- R2: When `en` is 1 and `tx_empty` is 1, a single-cycle `tx_wr` stores `tx_data`. At the following clock edge the transfer starts: `busy` rises, the selected `cs_n` bit goes low and `tx_empty` returns to 1.
- R3: Data order and pairing:
  - Characters are 8 bits, MSB first on `mosi`.
  - One `miso` bit is captured for each bit sent.
  - After completion, `rx_data` holds the captured bits with the first captured bit as the MSB.
- R4: Clock timing:
  - `sck` toggles exactly 16 times per character.
  - Each half period lasts `cfg_div` clock cycles, and `cfg_div` must be at least 2.
  - `sck` returns to the `cfg_cpol` level after every character.
- R5: With `cfg_cap_lead`=0:
  - `mosi` changes on the leading `sck` edge (the edge leaving the idle level).
  - `miso` is captured on the trailing edge.
  - Before the first edge of a character, `mosi` still holds the LSB of the previous character (0 after reset).
- R6: With `cfg_cap_lead`=1:
  - The MSB is on `mosi` from the cycle the select goes low.
  - `miso` is captured on the leading edge and `mosi` changes on the trailing edge.
- R7: Chaining:
  - A word written during a transfer is held (`tx_empty`=0) until the current character ends.
  - It is then sent with no idle half period and without raising the select.
  - Two chained characters keep the select low for exactly 33×`cfg_div` cycles.
- R8: A `tx_wr` while `tx_empty` is 0 is ignored; the held word is not replaced.
- R9: With nothing pending, the select is released one half period (`cfg_div` cycles) after the last trailing edge. A single character keeps it low for exactly 17×`cfg_div` cycles.
- R10: `rx_full` is set when a character completes and is cleared by a single-cycle `rx_rd`.
- R11: Overrun:
  - If a character completes while `rx_full` is 1 and `rx_rd` is not asserted in that cycle, `overrun` is set and `rx_data` takes the new word.
  - `rx_rd` clears `overrun`.
- R12: While `en` is 0, `tx_wr` is ignored and no transfer starts.
- R13: Selection and sampling:
  - During a transfer only `cs_n[cfg_sel]` is low.
  - `cfg_sel`, `cfg_cpol`, `cfg_cap_lead` and `cfg_div` are sampled when a transfer launches from idle.
  - They are held across chained characters.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Enables accepting writes and launching transfers |
| cfg_cpol | input | 1 | Idle level of `sck` |
| cfg_cap_lead | input | 1 | 1: capture on leading edge; 0: launch on leading edge |
| cfg_sel | input | SEL_W | Index of the slave select to drive |
| cfg_div | input | DIV_W | Half period of `sck` in clock cycles (at least 2) |
| tx_wr | input | 1 | Write strobe for the transmit holding register |
| tx_data | input | CHAR_W | Word to transmit |
| rx_rd | input | 1 | Read strobe; clears `rx_full` and `overrun` |
| rx_data | output | CHAR_W | Receive holding register |
| tx_empty | output | 1 | Transmit holding register is free |
| rx_full | output | 1 | Unread received word present |
| overrun | output | 1 | A received word replaced an unread one |
| busy | output | 1 | Engine is not idle |
| sck | output | 1 | Serial clock |
| mosi | output | 1 | Serial data to the slave |
| miso | input | 1 | Serial data from the slave |
| cs_n | output | NCS | Active-low slave selects |

## Verification
The embedded assertions check several properties on every cycle:
- Divider ticks are never adjacent, and a launch never uses a divider value below 2.
- The serial clock only moves on a tick.
- At most one select is low.
- The engine takes a word only when one is held, and a held word is never replaced.
- Every completion sets the receive flag, and overrun rises only at a completion.

Only the bench scenarios can show the end-to-end behaviour:
- The MSB-first data order and bit pairing in both phase modes, checked against a behavioural slave.
- The level of `mosi` before the first edge.
- The exact select-low durations for single and chained characters.
- Which select line fires, and that a disabled block ignores writes.

// File: rtl/spim_pkg.sv
package spim_pkg;

    typedef enum logic [1:0] {
        S_IDLE  = 2'd0,
        S_SHIFT = 2'd1,
        S_TAIL  = 2'd2
    } eng_state_e;

endpackage

// File: rtl/spim_baud.sv
module spim_baud #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [DIV_W-1:0] div,
    output logic             tick
);

    logic [DIV_W-1:0] cnt;
    logic             at_end;

    assign at_end = (cnt == (div - 1'b1));
    assign tick   = run && at_end;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (!run || at_end) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

    // R4: with a divider of at least 2, half-period ticks never touch
    p_tick_gap_r4: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> !tick);

endmodule

// File: rtl/spim_engine.sv
module spim_engine
    import spim_pkg::*;
#(
    parameter int CHAR_W = 8,
    parameter int NCS    = 4,
    parameter int DIV_W  = 8,
    parameter int SEL_W  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic              cfg_cpol,
    input  logic              cfg_cap_lead,
    input  logic [SEL_W-1:0]  cfg_sel,
    input  logic [DIV_W-1:0]  cfg_div,
    input  logic              pend_v,
    input  logic [CHAR_W-1:0] pend_d,
    input  logic              tick,
    input  logic              miso,
    output logic              run,
    output logic [DIV_W-1:0]  div_q,
    output logic              take,
    output logic              done,
    output logic [CHAR_W-1:0] rx_word,
    output logic              sck,
    output logic              mosi,
    output logic [NCS-1:0]    cs_n
);

    localparam int EDGES = 2 * CHAR_W;
    localparam int EC_W  = $clog2(EDGES);

    eng_state_e        state, state_nx;
    logic [EC_W-1:0]   ecnt;
    logic [CHAR_W-1:0] sh;
    logic              samp;
    logic              sck_q;
    logic              mosi_q;
    logic              cpol_q;
    logic              capl_q;
    logic [SEL_W-1:0]  sel_q;
    logic              last;
    logic              lead;
    logic              launch;
    logic              chain;

    assign last   = (ecnt == EC_W'(EDGES - 1));
    assign lead   = ~ecnt[0];
    assign launch = (state == S_IDLE) && pend_v && en;
    assign done   = (state == S_SHIFT) && tick && last;
    assign chain  = done && pend_v;
    assign take   = launch || chain;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= S_IDLE;
        end else begin
            state <= state_nx;
        end
    end

    // Transitions: launch, chain, drain, release
    always_comb begin
        state_nx = state;
        unique case (state)
            S_IDLE:  if (launch) state_nx = S_SHIFT;
            S_SHIFT: if (done && !pend_v) state_nx = S_TAIL;
            S_TAIL:  if (tick) state_nx = S_IDLE;
            default: state_nx = S_IDLE;
        endcase
    end

    // Shift path and serial outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ecnt   <= '0;
            sh     <= '0;
            samp   <= 1'b0;
            sck_q  <= 1'b0;
            mosi_q <= 1'b0;
            cpol_q <= 1'b0;
            capl_q <= 1'b0;
            sel_q  <= '0;
            div_q  <= DIV_W'(2);
        end else if (launch) begin
            cpol_q <= cfg_cpol;
            capl_q <= cfg_cap_lead;
            sel_q  <= cfg_sel;
            div_q  <= cfg_div;
            sck_q  <= cfg_cpol;
            sh     <= pend_d;
            ecnt   <= '0;
            if (cfg_cap_lead) mosi_q <= pend_d[CHAR_W-1];
        end else if ((state == S_SHIFT) && tick) begin
            sck_q <= ~sck_q;
            ecnt  <= last ? '0 : ecnt + 1'b1;
            if (capl_q) begin
                if (lead) begin
                    samp <= miso;
                end else begin
                    sh <= {sh[CHAR_W-2:0], samp};
                    if (!last) mosi_q <= sh[CHAR_W-2];
                end
            end else begin
                if (lead) mosi_q <= sh[CHAR_W-1];
                else      sh     <= {sh[CHAR_W-2:0], miso};
            end
            if (chain) begin
                sh <= pend_d;
                if (capl_q) mosi_q <= pend_d[CHAR_W-1];
            end
        end
    end

    // Outputs
    assign run     = (state != S_IDLE);
    assign sck     = (state == S_IDLE) ? cfg_cpol : sck_q;
    assign mosi    = mosi_q;
    assign rx_word = capl_q ? {sh[CHAR_W-2:0], samp} : {sh[CHAR_W-2:0], miso};

    for (genvar i = 0; i < NCS; i++) begin : g_cs
        assign cs_n[i] = !(run && (sel_q == SEL_W'(i)));
    end

    // R13: never more than one select low
    p_one_select_r13: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(~cs_n));
    // R4: a launch needs a divider of at least 2
    p_div_min_r4: assert property (@(posedge clk) disable iff (!rst_n)
        launch |-> (cfg_div >= DIV_W'(2)));
    // R4: the serial clock holds between ticks while shifting
    p_sck_on_tick_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_SHIFT && !tick && !launch) |=> $stable(sck_q));
    // R7: chaining keeps the engine busy with the clock at its idle level
    p_chain_busy_r7: assert property (@(posedge clk) disable iff (!rst_n)
        chain |=> (run && sck_q == cpol_q));

endmodule

// File: rtl/spim_master.sv
module spim_master #(
    parameter int CHAR_W = 8,
    parameter int NCS    = 4,
    parameter int DIV_W  = 8,
    localparam int SEL_W = (NCS > 1) ? $clog2(NCS) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic              cfg_cpol,
    input  logic              cfg_cap_lead,
    input  logic [SEL_W-1:0]  cfg_sel,
    input  logic [DIV_W-1:0]  cfg_div,
    input  logic              tx_wr,
    input  logic [CHAR_W-1:0] tx_data,
    input  logic              rx_rd,
    output logic [CHAR_W-1:0] rx_data,
    output logic              tx_empty,
    output logic              rx_full,
    output logic              overrun,
    output logic              busy,
    output logic              sck,
    output logic              mosi,
    input  logic              miso,
    output logic [NCS-1:0]    cs_n
);

    logic              tx_full;
    logic [CHAR_W-1:0] tx_hold;
    logic              take;
    logic              done;
    logic              tick;
    logic              run;
    logic [DIV_W-1:0]  div_q;
    logic [CHAR_W-1:0] rx_word;

    spim_baud #(.DIV_W(DIV_W)) u_baud (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (run),
        .div   (div_q),
        .tick  (tick)
    );

    spim_engine #(
        .CHAR_W (CHAR_W),
        .NCS    (NCS),
        .DIV_W  (DIV_W),
        .SEL_W  (SEL_W)
    ) u_eng (
        .clk          (clk),
        .rst_n        (rst_n),
        .en           (en),
        .cfg_cpol     (cfg_cpol),
        .cfg_cap_lead (cfg_cap_lead),
        .cfg_sel      (cfg_sel),
        .cfg_div      (cfg_div),
        .pend_v       (tx_full),
        .pend_d       (tx_hold),
        .tick         (tick),
        .miso         (miso),
        .run          (run),
        .div_q        (div_q),
        .take         (take),
        .done         (done),
        .rx_word      (rx_word),
        .sck          (sck),
        .mosi         (mosi),
        .cs_n         (cs_n)
    );

    // Transmit holding register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tx_full <= 1'b0;
            tx_hold <= '0;
        end else if (take) begin
            tx_full <= 1'b0;
        end else if (tx_wr && en && !tx_full) begin
            tx_full <= 1'b1;
            tx_hold <= tx_data;
        end
    end

    // Receive holding register and flags
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rx_data <= '0;
            rx_full <= 1'b0;
            overrun <= 1'b0;
        end else begin
            if (done) begin
                rx_data <= rx_word;
                rx_full <= 1'b1;
                if (rx_full && !rx_rd) overrun <= 1'b1;
                else if (rx_rd)        overrun <= 1'b0;
            end else if (rx_rd) begin
                rx_full <= 1'b0;
                overrun <= 1'b0;
            end
        end
    end

    assign tx_empty = !tx_full;
    assign busy     = run;

    // R2: the engine only takes a word that is actually held
    p_take_held_r2: assert property (@(posedge clk) disable iff (!rst_n)
        take |-> tx_full);
    // R8: a held word is never replaced before the engine takes it
    p_hold_kept_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_full && !take) |=> $stable(tx_hold));
    // R10: every completed character leaves the receive flag set
    p_done_full_r10: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> rx_full);
    // R11: overrun rises only at a completion
    p_ovr_cause_r11: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(overrun) |-> $past(done));

endmodule

// File: tb/spim_master_test.sv
module spim_master_test;

    localparam int CW  = 8;
    localparam int NCS = 4;
    localparam int DW  = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          en = 1'b1;
    logic          cpol_tb = 1'b0;
    logic          cl_tb = 1'b0;
    logic [1:0]    sel_tb = '0;
    logic [DW-1:0] div_tb = 8'd2;
    logic          tx_wr = 1'b0;
    logic [CW-1:0] tx_data = '0;
    logic          rx_rd = 1'b0;
    logic [CW-1:0] rx_data;
    logic          tx_empty, rx_full, overrun, busy, sck, mosi;
    logic          miso = 1'b0;
    logic [NCS-1:0] cs_n;
    logic          cs_line;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    int lowcnt = 0;
    int togg   = 0;
    logic [NCS-1:0] seen = '0;
    logic           sck_smp = 1'b0;

    logic [7:0] slv_out [4];
    logic [7:0] slv_in  [4];
    int   ci = 0;
    int   bp = 0;
    logic cs_prev  = 1'b1;
    logic sck_prev = 1'b0;

    spim_master #(.CHAR_W(CW), .NCS(NCS), .DIV_W(DW)) uut (
        .clk(clk), .rst_n(rst_n), .en(en), .cfg_cpol(cpol_tb),
        .cfg_cap_lead(cl_tb), .cfg_sel(sel_tb), .cfg_div(div_tb),
        .tx_wr(tx_wr), .tx_data(tx_data), .rx_rd(rx_rd), .rx_data(rx_data),
        .tx_empty(tx_empty), .rx_full(rx_full), .overrun(overrun),
        .busy(busy), .sck(sck), .mosi(mosi), .miso(miso), .cs_n(cs_n)
    );

    always #2 clk = ~clk;
    assign cs_line = &cs_n;

    // Behavioural slave
    always @(sck or cs_line) begin
        if (cs_line != cs_prev) begin
            cs_prev = cs_line;
            if (!cs_line) begin
                ci = 0;
                bp = 0;
                if (cl_tb) miso = slv_out[0][7];
            end
        end
        if (sck != sck_prev) begin
            sck_prev = sck;
            if (!cs_line && ci < 4) begin
                if (sck != cpol_tb) begin
                    if (!cl_tb) miso = slv_out[ci][7-bp];
                    else        slv_in[ci][7-bp] = mosi;
                end else begin
                    if (!cl_tb) slv_in[ci][7-bp] = mosi;
                    bp++;
                    if (bp == 8) begin bp = 0; ci++; end
                    if (cl_tb && ci < 4) miso = slv_out[ci][7-bp];
                end
            end
        end
    end

    // Bus observers
    always @(negedge clk) begin
        if (!cs_line) lowcnt++;
        if (!cs_line && sck != sck_smp) togg++;
        sck_smp = sck;
        seen    = seen | ~cs_n;
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            errors++;
            $display("FAIL watchdog: actual %0d expected %0d", cycles, 150000);
            finish_run();
        end
    end

    task automatic write_word(input logic [7:0] w);
        @(negedge clk);
        tx_data = w;
        tx_wr   = 1'b1;
        @(negedge clk);
        tx_wr   = 1'b0;
    endtask

    task automatic wait_idle();
        int n = 0;
        @(negedge clk);
        while (busy && n < 20000) begin
            @(negedge clk);
            n++;
        end
    endtask

    task automatic read_rx();
        @(negedge clk);
        rx_rd = 1'b1;
        @(negedge clk);
        rx_rd = 1'b0;
    endtask

    logic prev_lsb = 1'b0;

    task automatic one_xfer(input logic [7:0] tx, input logic [7:0] sv, input logic [1:0] s);
        int dv = int'(div_tb);
        slv_out[0] = sv;
        sel_tb = s;
        lowcnt = 0;
        togg   = 0;
        seen   = '0;
        write_word(tx);
        @(negedge clk);
        check(busy == 1'b1 && tx_empty == 1'b1, "R2 started", int'(busy), 1);
        if (cl_tb) check(mosi == tx[7], "R6 msb before first edge", int'(mosi), int'(tx[7]));
        else       check(mosi == prev_lsb, "R5 previous lsb held", int'(mosi), int'(prev_lsb));
        wait_idle();
        check(rx_data == sv, "R3 received word", int'(rx_data), int'(sv));
        check(slv_in[0] == tx, "R3 sent word", int'(slv_in[0]), int'(tx));
        check(togg == 16, "R4 edge count", togg, 16);
        check(lowcnt == 17 * dv, "R9 select low time", lowcnt, 17 * dv);
        check(seen == (4'b1 << s), "R13 select line", int'(seen), int'(4'b1 << s));
        check(sck == cpol_tb, "R4 idle level", int'(sck), int'(cpol_tb));
        check(rx_full == 1'b1, "R10 set on completion", int'(rx_full), 1);
        read_rx();
        check(rx_full == 1'b0, "R10 cleared by read", int'(rx_full), 0);
        prev_lsb = tx[0];
    endtask

    initial begin
        for (int k = 0; k < 4; k++) begin
            slv_out[k] = '0;
            slv_in[k]  = '0;
        end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check(cs_n == '1 && busy == 1'b0, "R1 idle selects", int'(cs_n), 15);
        check(tx_empty == 1'b1 && rx_full == 1'b0 && overrun == 1'b0,
              "R1 flags", int'({tx_empty, rx_full, overrun}), 4);
        check(sck == cpol_tb, "R1 idle clock", int'(sck), int'(cpol_tb));

        // Sweep of polarity, phase mode, divider and select
        for (int cp = 0; cp < 2; cp++) begin
            for (int cl = 0; cl < 2; cl++) begin
                for (int d = 0; d < 3; d++) begin
                    for (int i = 0; i < 3; i++) begin
                        int n = ((cp * 2 + cl) * 3 + d) * 3 + i;
                        cpol_tb = cp[0];
                        cl_tb   = cl[0];
                        div_tb  = (d == 0) ? 8'd2 : (d == 1) ? 8'd3 : 8'd5;
                        one_xfer(8'hA5 ^ 8'(n * 37), 8'h3C + 8'(n * 71), 2'(n));
                    end
                end
            end
        end

        // R7 and R8: chained characters, one extra write ignored
        cpol_tb = 1'b0;
        cl_tb   = 1'b0;
        div_tb  = 8'd3;
        sel_tb  = 2'd2;
        slv_out[0] = 8'h5A;
        slv_out[1] = 8'hC3;
        lowcnt = 0;
        togg   = 0;
        seen   = '0;
        write_word(8'h96);
        repeat (4) @(negedge clk);
        tx_data = 8'h2D;
        tx_wr   = 1'b1;
        @(negedge clk);
        check(tx_empty == 1'b0, "R7 word held during transfer", int'(tx_empty), 0);
        tx_data = 8'hF0;
        @(negedge clk);
        tx_wr = 1'b0;
        wait_idle();
        check(slv_in[0] == 8'h96, "R7 first word", int'(slv_in[0]), 150);
        check(slv_in[1] == 8'h2D, "R8 held word kept", int'(slv_in[1]), 45);
        check(ci == 2, "R8 extra write ignored", ci, 2);
        check(lowcnt == 33 * 3, "R7 no gap between characters", lowcnt, 99);
        check(togg == 32, "R7 edge count", togg, 32);
        check(rx_data == 8'hC3, "R11 newest word kept", int'(rx_data), 195);
        check(overrun == 1'b1 && rx_full == 1'b1, "R11 overrun set", int'(overrun), 1);
        check(tx_empty == 1'b1, "R7 holding drained", int'(tx_empty), 1);
        read_rx();
        check(overrun == 1'b0 && rx_full == 1'b0, "R11 read clears overrun",
              int'({overrun, rx_full}), 0);

        // R12 disabled block ignores writes
        en   = 1'b0;
        seen = '0;
        write_word(8'h77);
        repeat (8) @(negedge clk);
        check(busy == 1'b0 && tx_empty == 1'b1, "R12 write ignored", int'(busy), 0);
        check(seen == '0, "R12 no select", int'(seen), 0);
        en = 1'b1;
        repeat (4) @(negedge clk);
        check(busy == 1'b0, "R12 nothing pending after enable", int'(busy), 0);

        finish_run();
    end

endmodule